// File: doc/BRIEF.md
# JTAG Test Access Port with Scan-Through Instruction

This block is a test access port controller with five serial test pins, a 3-bit instruction register, a one-bit bypass register and a boundary register whose length is a parameter (151 cells by default). Alongside the usual boundary instructions, it has a user instruction called scan-through. Under scan-through, the core's internal scan chain and the boundary register are joined into one serial path between the data-in pin and the data-out pin. The whole internal scan chain can then be loaded and unloaded through the test port alone, so no dedicated scan pins are needed. Burn-in and diagnostic runs use this single path.

The core's scan chain sits outside the block. The block drives it through three signals: a scan-enable output, a scan-in output that carries the test data-in pin, and a scan-out input. That scan-out input feeds the first boundary cell. Each boundary cell has a shift stage and an update stage. Only the external-test instruction switches the pin outputs over from the core's functional values to the update stage.

Top module: `tap_scan_through`

## Requirements
- R1: A low level on `trst_n` resets the port at once, without waiting for a clock. The controller enters Test-Logic-Reset and the instruction becomes bypass. As a result `pin_out` equals `core_out`, `scan_en` is 0 and `tdo` is high-impedance.
- R2: With `tms` held high, the controller reaches Test-Logic-Reset from any state within five rising edges of `tck`. One rising edge later the instruction is bypass.
- R3: In Capture-IR the instruction shift register loads the binary value 001. It shifts out least significant bit first, so the first three `tdo` bits are 1, 0, 0.
- R4: The instruction codes are external test 000, sample 001, preload 010, scan-through 011 and bypass 111. Bypass, and every other code (100, 101, 110), selects the one-bit bypass register. That register captures 0 and delays `tdi` by one shift.
- R5: Under sample, Capture-DR loads `pin_in` into all `BSR_LEN` boundary cells. Shift-DR then moves cell 0 out first, and `pin_out` keeps following `core_out`.
- R6: Under external test, each rising edge of `tck` in Update-DR copies the shift stage into the update stage, and `pin_out` shows the update stage. The update stage does not change in any other state.
- R7: Under preload, a shifted pattern reaches the update stage while `pin_out` still follows `core_out`. A later external-test instruction drives that pattern to `pin_out` with no further data shift.
- R8: Under scan-through, `scan_en` is 1 only in Shift-DR and 0 in Capture-DR. `scan_in` carries `tdi`, and `scan_out` feeds boundary cell `BSR_LEN-1`. The path from `tdi` to `tdo` is therefore the core chain followed by the boundary register, with cell 0 nearest `tdo`. `pin_out` follows `core_out`.
- R9: `tdo` changes only on a falling edge of `tck`. It is driven only when the controller sits in Shift-IR or Shift-DR, and it is high-impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on the rising edge of `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, high-impedance outside the shift states |
| scan_en | output | 1 | Shift enable to the core scan chain |
| scan_in | output | 1 | Serial data into the core scan chain |
| scan_out | input | 1 | Serial data out of the core scan chain |
| core_out | input | BSR_LEN | Functional values the core presents to the pins |
| pin_in | input | BSR_LEN | Pin values captured by the boundary cells |
| pin_out | output | BSR_LEN | Values driven towards the pins |

## Verification
Every register in the block changes on a rising edge of `tck`, with one exception: the `tdo` output flop changes on the falling edge that follows. The bench therefore drives `tms` and `tdi` just after a falling edge. It reads `tdo` just after the next falling edge, which gives the bit belonging to the state entered at the rising edge before it. It reads `scan_en` and `pin_out` just after a rising edge, because they follow the new state or the new update stage on that same edge. The instruction reset that comes from Test-Logic-Reset lands one rising edge after the state is reached, so that check waits a sixth cycle. The shift sequences compare each `tdo` bit with a bit position worked out from the path order: the boundary cells first, then the core chain, then the data shifted in earlier.

// File: rtl/tap_st_pkg.sv
// Package: shared state and instruction types for the test access port.
// Assumes a 3-bit instruction register. The state encoding is local to the
// block and is never seen outside it.
package tap_st_pkg;
    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST   = 3'b000,
        OP_SAMPLE   = 3'b001,
        OP_PRELOAD  = 3'b010,
        OP_SCANTHRU = 3'b011,
        OP_BYPASS   = 3'b111
    } tap_op_t;

    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
// Module: tap_fsm
// The 16-state controller, stepped by tms on each rising edge of tck.
// Assumes trst_n is asynchronous and active low.
module tap_fsm
    import tap_st_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;
    logic [2:0] ones_run;

    // Next-state decode from the current state and tms
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with the test reset
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // Run length of consecutive high tms samples, saturating at five
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            ones_run <= 3'd0;
        else if (!tms)          ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    // R2
    tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));
endmodule

// File: rtl/tap_ir.sv
// Module: tap_ir
// Instruction shift and hold registers with the decoder. Any code that is
// not defined decodes to bypass. Test-Logic-Reset reloads bypass.
module tap_ir
    import tap_st_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_t state,
    input  logic       tdi,
    output tap_op_t    op,
    output logic       ir_so
);
    logic [IR_W-1:0] ir_sh;

    // Map a raw code onto a defined instruction
    function automatic tap_op_t decode(input logic [IR_W-1:0] code);
        case (code)
            3'b000:  return OP_EXTEST;
            3'b001:  return OP_SAMPLE;
            3'b010:  return OP_PRELOAD;
            3'b011:  return OP_SCANTHRU;
            default: return OP_BYPASS;
        endcase
    endfunction

    // Shift stage: load the capture value or shift towards tdo
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 ir_sh <= IR_CAPTURE;
        else if (state == ST_CAP_IR) ir_sh <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Hold stage: take the new code in Update-IR, revert to bypass in reset
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 op <= OP_BYPASS;
        else if (state == ST_RESET)  op <= OP_BYPASS;
        else if (state == ST_UPD_IR) op <= decode(ir_sh);
    end

    assign ir_so = ir_sh[0];

    // R4
    ir_legal_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (op == OP_EXTEST) || (op == OP_SAMPLE) || (op == OP_PRELOAD) ||
        (op == OP_SCANTHRU) || (op == OP_BYPASS));
endmodule

// File: rtl/tap_bsr.sv
// Module: tap_bsr
// Boundary register with a shift stage and an update stage per cell. Serial
// data enters cell LEN-1 and leaves from cell 0. The caller decides when the
// register is selected and when its update stage may load.
module tap_bsr
    import tap_st_pkg::*;
#(
    parameter int LEN = 151
) (
    input  logic           tck,
    input  logic           trst_n,
    input  tap_state_t     state,
    input  logic           sel,
    input  logic           upd_ok,
    input  logic           drive_pins,
    input  logic           si,
    input  logic [LEN-1:0] pin_in,
    input  logic [LEN-1:0] core_out,
    output logic [LEN-1:0] pin_out,
    output logic           so
);
    logic [LEN-1:0] sh_q;
    logic [LEN-1:0] upd_q;
    logic [LEN-1:0] sh_next;
    logic           do_upd;

    // Per-cell serial link and pin multiplexer
    for (genvar i = 0; i < LEN; i++) begin : g_cell
        if (i == LEN - 1) begin : g_head
            assign sh_next[i] = si;
        end else begin : g_link
            assign sh_next[i] = sh_q[i+1];
        end
        assign pin_out[i] = drive_pins ? upd_q[i] : core_out[i];
    end

    assign do_upd = (state == ST_UPD_DR) && upd_ok;

    // Shift stage: capture pins or shift one place towards cell 0
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                         sh_q <= '0;
        else if (sel && state == ST_CAP_DR)  sh_q <= pin_in;
        else if (sel && state == ST_SH_DR)   sh_q <= sh_next;
    end

    // Update stage: copy the shift stage in Update-DR
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     upd_q <= '0;
        else if (do_upd) upd_q <= sh_q;
    end

    assign so = sh_q[0];

    // R6
    upd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_UPD_DR && upd_ok) |=> $stable(upd_q));
endmodule

// File: rtl/tap_scan_through.sv
// Module: tap_scan_through
// Top of the test access port. Joins the controller, the instruction
// register, the bypass bit and the boundary register. Under scan-through it
// places the external core chain in front of the boundary register. tdo is
// retimed to the falling edge of tck.
module tap_scan_through
    import tap_st_pkg::*;
#(
    parameter int BSR_LEN = 151
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               scan_en,
    output logic               scan_in,
    input  logic               scan_out,
    input  logic [BSR_LEN-1:0] core_out,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic [BSR_LEN-1:0] pin_out
);
    tap_state_t state;
    tap_op_t    op;
    logic       ir_so;
    logic       bsr_so;
    logic       bsr_si;
    logic       byp_q;
    logic       dr_so;
    logic       tdo_q;
    logic       tdo_en;
    logic       bsr_sel;
    logic       bsr_upd_ok;
    logic       thru;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .op     (op),
        .ir_so  (ir_so)
    );

    // Instruction-dependent path controls
    assign thru       = (op == OP_SCANTHRU);
    assign bsr_sel    = (op == OP_EXTEST) || (op == OP_SAMPLE) ||
                        (op == OP_PRELOAD) || thru;
    assign bsr_upd_ok = (op == OP_EXTEST) || (op == OP_SAMPLE) || (op == OP_PRELOAD);
    assign bsr_si     = thru ? scan_out : tdi;

    tap_bsr #(.LEN(BSR_LEN)) u_bsr (
        .tck        (tck),
        .trst_n     (trst_n),
        .state      (state),
        .sel        (bsr_sel),
        .upd_ok     (bsr_upd_ok),
        .drive_pins (op == OP_EXTEST),
        .si         (bsr_si),
        .pin_in     (pin_in),
        .core_out   (core_out),
        .pin_out    (pin_out),
        .so         (bsr_so)
    );

    // Core chain controls
    assign scan_in = tdi;
    assign scan_en = thru && (state == ST_SH_DR);

    // Bypass bit: clear on capture, take tdi on shift
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 byp_q <= 1'b0;
        else if (state == ST_CAP_DR) byp_q <= 1'b0;
        else if (state == ST_SH_DR)  byp_q <= tdi;
    end

    assign dr_so = bsr_sel ? bsr_so : byp_q;

    // Output retiming on the falling edge, with the drive enable
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q  <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo_q  <= (state == ST_SH_IR) ? ir_so : dr_so;
        end
    end

    assign tdo = tdo_en ? tdo_q : 1'bz;

    // R8
    scan_en_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(scan_en) |-> ($past(state) == ST_CAP_DR || $past(state) == ST_EX2_DR));

    // R9
    tdo_drive_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));
endmodule

// File: tb/tap_scan_through_bench.sv
module tap_scan_through_bench;
    localparam int BSR = 151;
    localparam int CH  = 20;
    localparam int TOT = BSR + CH;

    logic           tck = 1'b0;
    logic           trst_n = 1'b0;
    logic           tms = 1'b1;
    logic           tdi = 1'b0;
    wire            tdo;
    logic           scan_en;
    logic           scan_in;
    logic           scan_out;
    logic [BSR-1:0] core_out;
    logic [BSR-1:0] pin_in;
    logic [BSR-1:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [CH-1:0] chain;
    logic [CH-1:0] chain_seed;
    logic          chain_load = 1'b0;

    logic se_cap, se_sh, tdo_pre;

    always #5 tck = ~tck;

    // Bench model of the core scan chain
    always @(posedge tck) begin
        if (chain_load)   chain <= chain_seed;
        else if (scan_en) chain <= {scan_in, chain[CH-1:1]};
    end
    assign scan_out = chain[0];

    tap_scan_through #(.BSR_LEN(BSR)) u_tap_scan_through (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
        .core_out(core_out), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One tck cycle: read tdo after the falling edge, drive, wait for the rise
    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic go(input logic m);
        logic unused;
        step(m, 1'b0, unused);
    endtask

    // From Run-Test/Idle: load a code, return the captured bits, end in idle
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 3; i++) step(i == 2, code[i], cap[i]);
        go(1); go(0);
    endtask

    // From Run-Test/Idle: a full data scan of n bits, end in idle
    task automatic shift_dr(input int n, input logic [511:0] din, output logic [511:0] dout);
        dout = '0;
        go(1); go(0);
        se_cap = scan_en;
        go(0);
        se_sh   = scan_en;
        tdo_pre = tdo;
        for (int i = 0; i < n; i++) step(i == n - 1, din[i], dout[i]);
        go(1); go(0);
    endtask

    task automatic t_reset_state;
        check("R1 tdo after reset", tdo, 1'bz);
        check("R1 scan_en after reset", scan_en, 1'b0);
        check("R1 pins after reset", pin_out, core_out);
    endtask

    task automatic t_ir_capture;
        logic [2:0] cap;
        load_ir(3'b111, cap);
        check("R3 capture-IR bits", cap, 3'b001);
    endtask

    task automatic t_bypass(input logic [2:0] code, input string tag);
        logic [2:0] cap;
        logic [511:0] o;
        logic [511:0] d;
        d = 512'h9B;
        load_ir(code, cap);
        shift_dr(9, d, o);
        check(tag, o[8:0], {d[7:0], 1'b0});
        check("R4 no scan_en under bypass", se_sh, 1'b0);
    endtask

    task automatic t_sample(input logic [BSR-1:0] p);
        logic [2:0] cap;
        logic [511:0] o;
        pin_in = p;
        load_ir(3'b001, cap);
        shift_dr(BSR, 512'h0, o);
        check("R5 sampled pins", o[BSR-1:0], p);
        check("R5 pins functional", pin_out, core_out);
    endtask

    task automatic t_extest(input logic [BSR-1:0] d, input logic [BSR-1:0] p);
        logic [2:0] cap;
        logic [511:0] o;
        pin_in = p;
        load_ir(3'b000, cap);
        shift_dr(BSR, {361'h0, d}, o);
        check("R6 extest capture", o[BSR-1:0], p);
        check("R6 pins from update stage", pin_out, d);
    endtask

    task automatic t_preload(input logic [BSR-1:0] e);
        logic [2:0] cap;
        logic [511:0] o;
        load_ir(3'b010, cap);
        shift_dr(BSR, {361'h0, e}, o);
        check("R7 pins untouched by preload", pin_out, core_out);
        load_ir(3'b000, cap);
        check("R7 preloaded value on pins", pin_out, e);
    endtask

    task automatic t_scan_through(input logic [BSR-1:0] p, input logic [CH-1:0] seed,
                                  input logic [TOT-1:0] d);
        logic [2:0] cap;
        logic [511:0] o;
        logic [511:0] din;
        logic [511:0] exp;
        pin_in = p;
        chain_seed = seed;
        load_ir(3'b011, cap);
        chain_load = 1'b1;
        go(0);
        chain_load = 1'b0;
        din = '0;
        din[TOT-1:0] = d;
        shift_dr(2 * TOT, din, o);
        check("R8 scan_en low in capture", se_cap, 1'b0);
        check("R8 scan_en high in shift", se_sh, 1'b1);
        check("R8 scan_en low in idle", scan_en, 1'b0);
        exp = '0;
        exp[BSR-1:0]       = p;
        exp[TOT-1:BSR]     = seed;
        exp[2*TOT-1:TOT]   = d;
        check("R8 joined path order", o, exp);
        check("R8 pins functional", pin_out, core_out);
        check("R9 tdo z before first fall", tdo_pre, 1'bz);
        check("R9 tdo z in idle", tdo, 1'bz);
    endtask

    task automatic t_async_reset(input logic [BSR-1:0] d);
        logic [2:0] cap;
        logic [511:0] o;
        load_ir(3'b000, cap);
        shift_dr(BSR, {361'h0, d}, o);
        go(1); go(0);
        @(negedge tck); #2;
        trst_n = 1'b0;
        #1;
        check("R1 async pins", pin_out, core_out);
        check("R1 async tdo", tdo, 1'bz);
        #3;
        trst_n = 1'b1;
        go(0);
    endtask

    task automatic t_tms_reset(input logic [BSR-1:0] d);
        logic [2:0] cap;
        logic [511:0] o;
        load_ir(3'b000, cap);
        shift_dr(BSR, {361'h0, d}, o);
        go(1); go(0); go(0);
        for (int i = 0; i < 6; i++) go(1);
        check("R2 bypass after tms ones", pin_out, core_out);
        go(0);
        shift_dr(3, 512'h5, o);
        check("R2 bypass path", o[2:0], 3'b010);
    endtask

    initial begin
        logic [159:0] a;
        logic [159:0] b;
        logic [159:0] c;
        logic [191:0] w;
        a = {5{32'h3C5A_9E17}};
        b = {5{32'hC0DE_F00D}};
        c = {5{32'h1234_ABCD}};
        w = {6{32'h6E2B_D591}};
        core_out   = b[BSR-1:0];
        pin_in     = '0;
        chain_seed = '0;
        #22;
        t_reset_state();
        trst_n = 1'b1;
        go(0);
        t_ir_capture();
        t_bypass(3'b111, "R4 bypass 111");
        t_bypass(3'b101, "R4 unused code 101");
        t_sample(a[BSR-1:0]);
        t_extest(c[BSR-1:0], a[BSR-1:0]);
        t_preload(a[BSR-1:0]);
        t_scan_through(c[BSR-1:0], 20'hA3C5F, w[TOT-1:0]);
        t_async_reset(a[BSR-1:0]);
        t_tms_reset(c[BSR-1:0]);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule